// File: doc/BRIEF.md
# Daisy-Chain Serial Shift Stage

This block is the receive-and-forward stage of a serial peripheral bus slave. Several stages can share one active-low select line, with the serial output of one stage wired to the serial input of the next. The whole chain then behaves as one long shift register. While select is low, each stage captures its serial input on rising serial clock edges. On falling edges it presents the bit pushed out of the top of its register. A downstream stage therefore sees, during one group of clock pulses, exactly the word this stage captured during the group before.

The serial clock, data input and select all arrive asynchronously. They are brought into the system clock domain through a parameterised synchronizer, and their edges are detected there. The falling edge of select preloads the register from a parallel load word, so that local data leaves first. The rising edge of select commits the register to a parallel output and raises a one-cycle valid pulse. The stage does not need to know how long the chain is. Only clock mode 0 is supported: the clock idles low, data is sampled on the rising edge, and data changes on the falling edge.

Top module: `chain_spi_stage`

## Requirements
- R1: After reset, `par_dout` is 0, `par_dout_vld` is 0 and `ser_oe` is 0.
- R2: On the falling edge of `spi_csn`, the shift register takes the value of `par_load`. Bit `WIDTH-1` of `par_load` appears on `ser_out` before the first rising edge of `spi_sclk`.
- R3: On each rising edge of `spi_sclk` while selected, the register shifts toward its most significant bit. The sampled `spi_mosi` enters at bit 0.
- R4: `ser_out` changes only after a falling edge of `spi_sclk` while selected, or after the falling edge of select. After a falling edge it shows the register's bit `WIDTH-1`. As a result, the bit presented before rising edge k (counting from 0) equals `par_load[WIDTH-1-k]` for k < WIDTH, and equals the `spi_mosi` bit captured at edge k-WIDTH otherwise.
- R5: On the rising edge of `spi_csn`, `par_dout` takes the register contents, and `par_dout_vld` is high for exactly one system clock. `par_dout` changes at no other time.
- R6: When the number of clocks in a frame is not WIDTH, `par_dout` holds the last WIDTH bits shifted in. For a short frame of n bits, this is `par_load[WIDTH-1-n:0]` followed by the n received bits. For a long frame, it is the last WIDTH received bits.
- R7: While `spi_csn` is high, activity on `spi_sclk` and `spi_mosi` has no effect. `ser_out` stays stable, no valid pulse is raised, and `par_dout` keeps its value.
- R8: `ser_oe` is high while the synchronized select is low and low otherwise. It is low in the cycle where `par_dout_vld` is high.
- R9: `par_dout_vld` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data in from upstream |
| spi_csn | input | 1 | Shared active-low select |
| par_load | input | WIDTH | Word preloaded when select falls |
| ser_out | output | 1 | Serial data to downstream stage |
| ser_oe | output | 1 | Enable for the serial output pad |
| par_dout | output | WIDTH | Word committed when select rises |
| par_dout_vld | output | 1 | One-cycle pulse when `par_dout` updates |

## Verification
A corrupted shift register shows up first on `ser_out`. A wrong bit appears at the next sample point and again WIDTH serial clocks later, so comparing the serial output bit by bit against a model catches it within one frame. A wrong edge detector shows up in one of two ways. A lost or extra sample shifts the whole output stream by one position. A select edge that is missed or seen twice shows up as a missing or doubled valid pulse within a few system clocks of select rising. Short and long frames check that the committed word is the last WIDTH bits, not the first.

// File: rtl/chain_spi_pkg.sv
package chain_spi_pkg;

   // raw pins as seen at the block edge
   typedef struct packed {
      logic sclk;
      logic mosi;
      logic csn;
   } spi_pins_t;

   localparam int PIN_BITS = $bits(spi_pins_t);

   // events in the system clock domain
   typedef struct packed {
      logic sclk_rise;
      logic sclk_fall;
      logic sel_fall;
      logic sel_rise;
      logic selected;
      logic mosi;
   } spi_evt_t;

endpackage

// File: rtl/chain_spi_sync.sv
module chain_spi_sync #(
   parameter int             WIDTH   = 3,
   parameter int             STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("chain_spi_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= RST_VAL;
               else        stage_q[s] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= RST_VAL;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/chain_spi_edge.sv
module chain_spi_edge
   import chain_spi_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  spi_pins_t pins_sync,
   output spi_evt_t  evt
);

   logic sclk_q;
   logic csn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         csn_q  <= 1'b1;
      end else begin
         sclk_q <= pins_sync.sclk;
         csn_q  <= pins_sync.csn;
      end
   end

   always_comb begin
      evt.sclk_rise = pins_sync.sclk  & ~sclk_q;
      evt.sclk_fall = ~pins_sync.sclk & sclk_q;
      evt.sel_fall  = ~pins_sync.csn  & csn_q;
      evt.sel_rise  = pins_sync.csn   & ~csn_q;
      evt.selected  = ~pins_sync.csn;
      evt.mosi      = pins_sync.mosi;
   end

endmodule

// File: rtl/chain_spi_shift.sv
module chain_spi_shift
   import chain_spi_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  spi_evt_t         evt,
   input  logic [WIDTH-1:0] load_word,
   output logic             out_bit,
   output logic             out_en,
   output logic [WIDTH-1:0] commit_word,
   output logic             commit_vld
);

   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("chain_spi_shift: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q        <= '0;
         out_bit     <= 1'b0;
         out_en      <= 1'b0;
         commit_word <= '0;
         commit_vld  <= 1'b0;
      end else begin
         commit_vld <= 1'b0;
         if (evt.sel_fall) begin
            sh_q    <= load_word;
            out_bit <= load_word[MSB];
            out_en  <= 1'b1;
         end else if (evt.sel_rise) begin
            commit_word <= sh_q;
            commit_vld  <= 1'b1;
            out_en      <= 1'b0;
         end else if (evt.selected) begin
            if (evt.sclk_rise) sh_q    <= {sh_q[MSB-1:0], evt.mosi};
            if (evt.sclk_fall) out_bit <= sh_q[MSB];
         end
      end
   end

endmodule

// File: rtl/chain_spi_stage.sv
module chain_spi_stage
   import chain_spi_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             spi_sclk,
   input  logic             spi_mosi,
   input  logic             spi_csn,
   input  logic [WIDTH-1:0] par_load,
   output logic             ser_out,
   output logic             ser_oe,
   output logic [WIDTH-1:0] par_dout,
   output logic             par_dout_vld
);

   localparam spi_pins_t PIN_RST = '{sclk: 1'b0, mosi: 1'b0, csn: 1'b1};

   spi_pins_t pins_raw;
   spi_pins_t pins_sync;
   spi_evt_t  evt;

   assign pins_raw = '{sclk: spi_sclk, mosi: spi_mosi, csn: spi_csn};

   chain_spi_sync #(
      .WIDTH   (PIN_BITS),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_RST)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pins_raw),
      .q_sync  (pins_sync)
   );

   chain_spi_edge u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .pins_sync (pins_sync),
      .evt       (evt)
   );

   chain_spi_shift #(
      .WIDTH (WIDTH)
   ) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt         (evt),
      .load_word   (par_load),
      .out_bit     (ser_out),
      .out_en      (ser_oe),
      .commit_word (par_dout),
      .commit_vld  (par_dout_vld)
   );

endmodule

// File: rtl/chain_spi_stage_chk.sv
module chain_spi_stage_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ser_out,
   input logic             ser_oe,
   input logic [WIDTH-1:0] par_dout,
   input logic             par_dout_vld,
   input logic             sclk_fall,
   input logic             sel_fall,
   input logic             selected
);

   AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      par_dout_vld |=> !par_dout_vld); // R9

   AST_DOUT_ONLY_ON_VLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(par_dout) |-> par_dout_vld); // R5

   AST_OE_LOW_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      par_dout_vld |-> !ser_oe); // R8

   AST_SDO_QUIET_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
      (!ser_oe && $past(!ser_oe)) |-> $stable(ser_out)); // R7

   AST_SDO_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ser_out) |-> $past((sclk_fall && selected) || sel_fall)); // R4

endmodule

bind chain_spi_stage chain_spi_stage_chk #(.WIDTH(WIDTH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ser_out      (ser_out),
   .ser_oe       (ser_oe),
   .par_dout     (par_dout),
   .par_dout_vld (par_dout_vld),
   .sclk_fall    (evt.sclk_fall),
   .sel_fall     (evt.sel_fall),
   .selected     (evt.selected)
);

// File: tb/test_chain_spi_stage.sv
module test_chain_spi_stage;

   localparam int W    = 8;
   localparam int HALF = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         spi_sclk = 1'b0;
   logic         spi_mosi = 1'b0;
   logic         spi_csn = 1'b1;
   logic [W-1:0] par_load = '0;
   logic         ser_out;
   logic         ser_oe;
   logic [W-1:0] par_dout;
   logic         par_dout_vld;

   int n_checks = 0;
   int n_fail   = 0;
   logic [W-1:0] exp_q [$];
   logic [W-1:0] model;

   always #5 clk = ~clk;

   chain_spi_stage #(.WIDTH(W)) i_chain_spi_stage (
      .clk          (clk),
      .rst_n        (rst_n),
      .spi_sclk     (spi_sclk),
      .spi_mosi     (spi_mosi),
      .spi_csn      (spi_csn),
      .par_load     (par_load),
      .ser_out      (ser_out),
      .ser_oe       (ser_oe),
      .par_dout     (par_dout),
      .par_dout_vld (par_dout_vld)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // monitor: pops the expected committed word on each valid pulse (R5, R6, R9)
   logic vld_prev = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (par_dout_vld) begin
            if (vld_prev) check("R9 double pulse", 1, 0);
            if (exp_q.size() == 0) begin
               check("R5/R7 unexpected valid", 1, 0);
            end else begin
               check("R5 committed word", par_dout, exp_q.pop_front());
            end
         end
         vld_prev <= par_dout_vld;
      end
   end

   // driver: one frame of n bits, bits sent from bits[n-1] down to bits[0]
   task automatic frame(input logic [W-1:0] load, input logic [31:0] bits, input int n);
      par_load = load;
      model    = load;
      spi_csn  = 1'b0;
      wait_clk(HALF);
      check("R8 oe while selected", ser_oe, 1);
      for (int k = 0; k < n; k++) begin
         spi_mosi = bits[n-1-k];
         wait_clk(HALF);
         check(k == 0 ? "R2 first bit is load msb" : "R4 serial out", ser_out, model[W-1]);
         spi_sclk = 1'b1;
         model    = {model[W-2:0], bits[n-1-k]}; // R3
         wait_clk(HALF);
         spi_sclk = 1'b0;
      end
      wait_clk(HALF);
      exp_q.push_back(model);
      spi_csn = 1'b1;
      wait_clk(HALF);
      check("R5 dout after select rise", par_dout, model);
      check("R8 oe low after deselect", ser_oe, 0);
      check("R5 queue drained", exp_q.size(), 0);
   endtask

   initial begin : watchdog
      wait_clk(150000);
      check("watchdog expired", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : stim
      logic held;
      logic [W-1:0] dout_before;
      wait_clk(3);
      // R1 reset state
      check("R1 dout", par_dout, 0);
      check("R1 vld", par_dout_vld, 0);
      check("R1 oe", ser_oe, 0);
      rst_n = 1'b1;
      wait_clk(4);

      // full frames, R2 R3 R4
      frame(8'hA5, 32'h3C, W);
      frame(8'h00, 32'hFF, W);
      frame(8'hFF, 32'h00, W);
      // two words in a row: second word echoes the first (R4)
      frame(8'h81, 32'h5A96, 2*W);
      // R6 short and long frames
      frame(8'hC3, 32'h5, 3);
      frame(8'h7E, 32'h1ABC, 13);
      frame(8'h12, 32'h1, 1);

      // R7: activity while deselected is ignored
      held        = ser_out;
      dout_before = par_dout;
      for (int i = 0; i < 10; i++) begin
         spi_mosi = i[0];
         spi_sclk = ~spi_sclk;
         wait_clk(HALF);
         check("R7 ser_out stable while deselected", ser_out, held);
         check("R7 oe low while deselected", ser_oe, 0);
      end
      spi_sclk = 1'b0;
      wait_clk(HALF);
      check("R7 dout unchanged", par_dout, dout_before);

      // frame after idle activity still behaves
      frame(8'h69, 32'hE1, W);

      wait_clk(10);
      check("R5 no pending commits", exp_q.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule